// File: doc/BRIEF.md
# Camera Parallel Byte Output Formatter

This block turns a stream of 16-bit pixels into the byte-wide parallel output of a camera port. Each pixel goes out as two bytes on `dout`, and a companion data clock comes with it. A horizontal window signal is high while a line carries bytes. A vertical window signal is high while a frame carries lines. An output-size code sets the line geometry and the divider ratio for that size: the number of byte slots with data, the number of blanking slots that follow them, and how many processing-clock cycles each byte slot lasts. A format bit selects one of two byte layouts. One is luminance/chroma 4:2:2, chroma byte first. The other is 5:6:5 colour, split low half first.

Pixels come in on a valid/ready handshake. The block raises `in_ready` for exactly one cycle at the start of every even data slot, so it asks for one pixel per two data bytes. It never waits for the source. The line timing is free-running and the source must keep up. If no pixel is offered when one is asked for, the port holds its last byte and a sticky underrun flag is set. All outputs change only on the launch edge of the data clock. A polarity bit chooses whether that launch edge is the rising or the falling edge. The size code and the format bit are sampled once per frame.

Top module: `camfmt_top`

## Requirements
- R1: `in_ready` is high for one cycle at the launch of each even data slot (slot 0, 2, 4… of a line), and never during reset. A pixel is taken when `in_valid` and `in_ready` are both high. The source must hold `in_pix` steady until it is taken, and exactly one pixel is taken per two data bytes.
- R2: With `cfg_rgb`=0, the first byte of a pixel is `in_pix[15:8]` (chroma) and the second is `in_pix[7:0]` (luma). When the source alternates U and V on successive pixels, a pixel pair goes out as U(n), Y(n), V(n), Y(n+1).
- R3: With `cfg_rgb`=1, `in_pix` holds R in bits 15:11, G in 10:5 and B in 4:0. The first byte is {G[2:0], B[4:0]} and the second is {R[4:0], G[5:3]}.
- R4: `cfg_size` sets data slots, blanking slots and clock division per line: 0 → 2560/224 ÷1, 1 → 1280/112 ÷2, 2 → 704/688 ÷2, 3 → 640/56 ÷4, 4 → 352/344 ÷4, 5 → 320/376 ÷4, 6 → 256/440 ÷4. Code 7 behaves as 0.
- R5: `hblk` is high exactly during the data slots of active lines. `dout` is 0 whenever `hblk` is low.
- R6: A frame lasts `TOTAL_LINES` line periods. `vblk` is high during the first `ACT_LINES` of them, and `hblk` stays low on the rest.
- R7: `dclk_en` is high for one processing cycle per byte slot, the cycle in which the new byte appears. `dout`, `hblk` and `vblk` change in no other cycle.
- R8: In divided sizes, `dclk_o` moves to the launch level (1 when `cfg_pol`=0, 0 when `cfg_pol`=1) in the cycle the outputs change, and leaves it half a slot later. In the undivided size, `dclk_o` rests at the launch level and the processing clock itself serves as the data clock.
- R9: If `in_valid` is low when `in_ready` is high, `dout` keeps its previous value for that slot and the following one, and `underrun` goes high and stays high until reset.
- R10: `cfg_size` and `cfg_rgb` are sampled at the first slot of each frame. A change in the middle of a frame does not alter the rest of that frame.
- R11: During reset, `dout`, `hblk`, `vblk`, `dclk_en`, `underrun` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 3 | Output-size code |
| cfg_rgb | input | 1 | 1 selects 5:6:5 colour, 0 selects 4:2:2 |
| cfg_pol | input | 1 | 0 launches on the rising data-clock edge, 1 on the falling edge |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel requested this cycle |
| in_pix | input | 16 | Pixel value |
| dout | output | 8 | Parallel output byte |
| dclk_o | output | 1 | Divided data clock level |
| dclk_en | output | 1 | One-cycle strobe marking each new byte slot |
| hblk | output | 1 | High during the data slots of a line |
| vblk | output | 1 | High during the active lines of a frame |
| underrun | output | 1 | Sticky missed-pixel flag |

## Verification
The first line after reset is captured in every size code, including the alias code 7. Each capture measures data slots, blanking slots and cycles per slot, which tells the table rows and the three divider ratios apart. The pixel source emits a position-dependent value that has no symmetry between its bytes. This lets the byte comparison separate the chroma-first layout from the low-half-first colour split, and it also catches a swapped, skipped or repeated pixel. Three further patterns are used. A starved source checks the hold-and-flag path. A size change in the middle of a frame checks that the new size waits for the next frame. A whole frame is timed to check the vertical window and the quiet lines.

// File: rtl/camfmt_pkg.sv
package camfmt_pkg;
  localparam int PIX_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int COL_W    = 12;
  localparam int DIVLOG_W = 2;
  localparam int PH_W     = 2;

  typedef struct packed {
    logic [COL_W-1:0]    act;
    logic [COL_W-1:0]    total;
    logic [DIVLOG_W-1:0] div_log;
  } line_geom_t;

  function automatic line_geom_t geom_of(input logic [2:0] code);
    line_geom_t g;
    case (code)
      3'd1:    g = '{act: 12'd1280, total: 12'd1392, div_log: 2'd1};
      3'd2:    g = '{act: 12'd704,  total: 12'd1392, div_log: 2'd1};
      3'd3:    g = '{act: 12'd640,  total: 12'd696,  div_log: 2'd2};
      3'd4:    g = '{act: 12'd352,  total: 12'd696,  div_log: 2'd2};
      3'd5:    g = '{act: 12'd320,  total: 12'd696,  div_log: 2'd2};
      3'd6:    g = '{act: 12'd256,  total: 12'd696,  div_log: 2'd2};
      default: g = '{act: 12'd2560, total: 12'd2784, div_log: 2'd0};
    endcase
    return g;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [PIX_W-1:0] p,
                                                  input logic rgb, input logic second);
    // colour layout sends low half first, luma/chroma layout high half first
    if (rgb ^ second) return p[BYTE_W-1:0];
    else              return p[PIX_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/camfmt_clkdiv.sv
module camfmt_clkdiv
  import camfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIVLOG_W-1:0] div_log,
  input  logic                pol,
  output logic                stb,
  output logic                dclk_o
);
  logic [PH_W-1:0] ph;
  logic [PH_W:0]   dv;
  logic [PH_W-1:0] last;
  logic [PH_W-1:0] half;

  assign dv   = {{PH_W{1'b0}}, 1'b1} << div_log;
  assign last = dv[PH_W-1:0] - 1'b1;
  assign half = dv[PH_W:1];
  assign stb  = (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      dclk_o <= 1'b0;
    end else begin
      ph <= (ph >= last) ? '0 : ph + 1'b1;
      if (stb)             dclk_o <= ~pol;
      else if (ph == half) dclk_o <= pol;
    end
  end
endmodule

// File: rtl/camfmt_raster.sv
module camfmt_raster
  import camfmt_pkg::*;
#(
  parameter int ACT_LINES   = 1024,
  parameter int TOTAL_LINES = 1052,
  parameter int LINE_W      = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic [2:0]          cfg_size,
  input  logic                cfg_rgb,
  output logic [DIVLOG_W-1:0] div_log,
  output logic                rgb,
  output logic                slot_act,
  output logic                line_act,
  output logic                odd_byte
);
  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic [2:0]        cur_size;
  logic              cur_rgb;
  logic              frame_top;
  line_geom_t        geom;

  assign frame_top = (col == '0) && (line == '0);
  assign geom      = geom_of(frame_top ? cfg_size : cur_size);
  assign rgb       = frame_top ? cfg_rgb : cur_rgb;
  assign div_log   = geom.div_log;
  assign line_act  = int'(line) < ACT_LINES;
  assign slot_act  = line_act && (col < geom.act);
  assign odd_byte  = col[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      line     <= '0;
      cur_size <= '0;
      cur_rgb  <= 1'b0;
    end else if (stb) begin
      if (frame_top) begin
        cur_size <= cfg_size;
        cur_rgb  <= cfg_rgb;
      end
      if (col == geom.total - 1'b1) begin
        col  <= '0;
        line <= (int'(line) == TOTAL_LINES - 1) ? '0 : line + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/camfmt_packer.sv
module camfmt_packer
  import camfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              slot_act,
  input  logic              odd_byte,
  input  logic              rgb,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic [BYTE_W-1:0] dout,
  output logic              underrun
);
  logic [PIX_W-1:0] held;
  logic             have;

  assign in_ready = rst_n && stb && slot_act && !odd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      have     <= 1'b0;
      dout     <= '0;
      underrun <= 1'b0;
    end else if (stb) begin
      if (!slot_act) begin
        dout <= '0;
        have <= 1'b0;
      end else if (!odd_byte) begin
        if (in_valid) begin
          held <= in_pix;
          have <= 1'b1;
          dout <= pick_byte(in_pix, rgb, 1'b0);
        end else begin
          have     <= 1'b0;
          underrun <= 1'b1;
        end
      end else if (have) begin
        dout <= pick_byte(held, rgb, 1'b1);
      end
    end
  end
endmodule

// File: rtl/camfmt_top.sv
module camfmt_top
  import camfmt_pkg::*;
#(
  parameter int ACT_LINES   = 1024,
  parameter int TOTAL_LINES = 1052
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_rgb,
  input  logic              cfg_pol,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic [BYTE_W-1:0] dout,
  output logic              dclk_o,
  output logic              dclk_en,
  output logic              hblk,
  output logic              vblk,
  output logic              underrun
);
  localparam int LINE_W = (TOTAL_LINES > 1) ? $clog2(TOTAL_LINES) : 1;

  logic                stb;
  logic [DIVLOG_W-1:0] div_log;
  logic                rgb;
  logic                slot_act;
  logic                line_act;
  logic                odd_byte;

  camfmt_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .div_log(div_log), .pol(cfg_pol),
    .stb(stb), .dclk_o(dclk_o)
  );

  camfmt_raster #(.ACT_LINES(ACT_LINES), .TOTAL_LINES(TOTAL_LINES), .LINE_W(LINE_W)) u_ras (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cfg_size(cfg_size), .cfg_rgb(cfg_rgb),
    .div_log(div_log), .rgb(rgb), .slot_act(slot_act), .line_act(line_act),
    .odd_byte(odd_byte)
  );

  camfmt_packer u_pack (
    .clk(clk), .rst_n(rst_n), .stb(stb), .slot_act(slot_act), .odd_byte(odd_byte),
    .rgb(rgb), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .dout(dout), .underrun(underrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_en <= 1'b0;
      hblk    <= 1'b0;
      vblk    <= 1'b0;
    end else begin
      dclk_en <= stb;
      if (stb) begin
        hblk <= slot_act;
        vblk <= line_act;
      end
    end
  end
endmodule

// File: rtl/camfmt_checker.sv
module camfmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pol,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] dout,
  input logic       dclk_o,
  input logic       dclk_en,
  input logic       hblk,
  input logic       vblk,
  input logic       underrun
);
  p_ready_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hblk |-> (dout == 8'd0));

  p_hblk_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hblk |-> vblk);

  p_change_on_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dout) || !$stable(hblk) || !$stable(vblk)) |-> dclk_en);

  p_launch_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_en && !$stable(dclk_o)) |-> (dclk_o == !$past(cfg_pol)));

  p_hold_on_starve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(dout));

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(in_ready && !in_valid));
endmodule

bind camfmt_top camfmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .in_valid(in_valid),
  .in_ready(in_ready), .dout(dout), .dclk_o(dclk_o), .dclk_en(dclk_en),
  .hblk(hblk), .vblk(vblk), .underrun(underrun)
);

// File: tb/camfmt_top_bench.sv
`timescale 1ns/1ps
module camfmt_top_bench;
  localparam int LINE_CYC = 2784;
  localparam int ACTL = 3;
  localparam int TOTL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_size = 3'd0;
  logic        cfg_rgb = 1'b0;
  logic        cfg_pol = 1'b0;
  logic        feed_on = 1'b1;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_pix;
  logic [7:0]  dout;
  logic        dclk_o, dclk_en, hblk, vblk, underrun;
  int          pix_idx;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  camfmt_top #(.ACT_LINES(ACTL), .TOTAL_LINES(TOTL)) u_camfmt_top (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_rgb(cfg_rgb), .cfg_pol(cfg_pol),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .dout(dout),
    .dclk_o(dclk_o), .dclk_en(dclk_en), .hblk(hblk), .vblk(vblk), .underrun(underrun)
  );

  function automatic logic [15:0] pix_of(input int k);
    return 16'(k * 16'h0923 + 16'h1357);
  endfunction

  assign in_valid = feed_on;
  assign in_pix   = pix_of(pix_idx);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) pix_idx <= 0;
    else if (in_valid && in_ready) pix_idx <= pix_idx + 1;

  function automatic logic [7:0] exp_byte(input int idx, input bit rgb);
    logic [15:0] p;
    logic [4:0]  r, b;
    logic [5:0]  g;
    p = pix_of(idx / 2);
    r = p[15:11]; g = p[10:5]; b = p[4:0];
    if (rgb) return (idx % 2 == 0) ? {g[2:0], b} : {r, g[5:3]};
    return (idx % 2 == 0) ? p[15:8] : p[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] sz, input bit rgb, input bit pol);
    @(negedge clk);
    rst_n = 1'b0; cfg_size = sz; cfg_rgb = rgb; cfg_pol = pol; feed_on = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // captures one line starting at its first data slot; ends at next line's first data slot
  task automatic capture_line(input bit rgb, output int act, output int blank,
                              output int bad, output int gap, output int stray);
    logic [7:0] pd;
    logic       ph;
    act = 0; blank = 0; bad = 0; gap = 0; stray = 0;
    do @(negedge clk); while (!(dclk_en && hblk));
    pd = dout; ph = hblk;
    for (int c = 0; c < 20000; c++) begin
      if (c > 0) begin
        @(negedge clk);
        if ((dout !== pd || hblk !== ph) && !dclk_en) stray++;
        pd = dout; ph = hblk;
      end
      if (dclk_en) begin
        if (hblk) begin
          if (blank > 0) break;
          if (dout !== exp_byte(act, rgb)) bad++;
          act++;
          if (act == 2) gap = c;
        end else begin
          blank++;
          if (dout !== 8'd0) bad++;
        end
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout == 8'd0, "R11", "dout in reset", dout, 0);
    chk(!hblk && !vblk, "R11", "hblk|vblk in reset", hblk | vblk, 0);
    chk(!dclk_en, "R11", "dclk_en in reset", dclk_en, 0);
    chk(!underrun, "R11", "underrun in reset", underrun, 0);
    chk(!in_ready, "R11", "in_ready in reset", in_ready, 0);
  endtask

  task automatic t_line(input logic [2:0] sz, input bit rgb, input bit pol,
                        input int ea, input int eb, input int ed);
    int a, b, bad, gap, stray;
    do_reset(sz, rgb, pol);
    capture_line(rgb, a, b, bad, gap, stray);
    chk(a == ea, "R4", $sformatf("size %0d data slots", sz), a, ea);
    chk(b == eb, "R4", $sformatf("size %0d blank slots", sz), b, eb);
    chk(gap == ed, "R4", $sformatf("size %0d cycles per slot", sz), gap, ed);
    chk(bad == 0, rgb ? "R3" : "R2", $sformatf("size %0d byte mismatches", sz), bad, 0);
    chk(stray == 0, "R7", $sformatf("size %0d changes off launch", sz), stray, 0);
    chk(dclk_o == !pol, "R8", "dclk_o at launch", dclk_o, !pol);
    repeat ((ed > 1) ? ed / 2 : 1) @(negedge clk);
    chk(dclk_o == ((ed > 1) ? pol : !pol), "R8", "dclk_o mid slot", dclk_o, (ed > 1) ? pol : !pol);
  endtask

  task automatic t_ready;
    int rdy, p0;
    do_reset(3'd3, 1'b0, 1'b0);
    @(negedge clk);
    rdy = 0; p0 = pix_idx;
    for (int c = 0; c < LINE_CYC; c++) begin
      if (in_ready) rdy++;
      @(negedge clk);
    end
    chk(rdy == 320, "R1", "ready pulses per line", rdy, 320);
    chk(pix_idx - p0 == 320, "R1", "pixels taken per line", pix_idx - p0, 320);
  endtask

  task automatic t_frame;
    int hi, lo, rises, bad;
    logic ph;
    do_reset(3'd0, 1'b0, 1'b0);
    @(negedge clk);
    hi = 0; rises = 0; ph = 1'b0;
    while (vblk && hi < 20000) begin
      if (hblk && !ph) rises++;
      ph = hblk; hi++;
      @(negedge clk);
    end
    lo = 0; bad = 0;
    while (!vblk && lo < 20000) begin
      if (hblk || dout != 8'd0) bad++;
      lo++;
      @(negedge clk);
    end
    chk(hi == ACTL * LINE_CYC, "R6", "vblk high cycles", hi, ACTL * LINE_CYC);
    chk(lo == (TOTL - ACTL) * LINE_CYC, "R6", "vblk low cycles", lo, (TOTL - ACTL) * LINE_CYC);
    chk(rises == ACTL, "R6", "data lines per frame", rises, ACTL);
    chk(bad == 0, "R5", "activity on quiet line", bad, 0);
  endtask

  task automatic t_underrun;
    logic [7:0] hv;
    int moved;
    do_reset(3'd0, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    chk(!underrun, "R9", "underrun while fed", underrun, 0);
    feed_on = 1'b0;
    repeat (4) @(negedge clk);
    hv = dout; moved = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (dout !== hv) moved++;
    end
    chk(hblk, "R9", "still in data slots", hblk, 1);
    chk(moved == 0, "R9", "byte changes while starved", moved, 0);
    chk(underrun, "R9", "underrun raised", underrun, 1);
    feed_on = 1'b1;
    repeat (10) @(negedge clk);
    chk(underrun, "R9", "underrun sticky", underrun, 1);
  endtask

  task automatic t_latch;
    int a, b, bad, gap, stray;
    do_reset(3'd0, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    cfg_size = 3'd3; cfg_rgb = 1'b1;
    while (hblk) @(negedge clk);
    capture_line(1'b0, a, b, bad, gap, stray);
    chk(a == 2560, "R10", "same-frame line keeps size", a, 2560);
    chk(gap == 1, "R10", "same-frame line keeps divider", gap, 1);
    while (vblk) @(negedge clk);
    capture_line(1'b1, a, b, bad, gap, stray);
    chk(a == 640, "R10", "next frame takes size", a, 640);
    chk(gap == 4, "R10", "next frame takes divider", gap, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_line(3'd0, 1'b0, 1'b0, 2560, 224, 1);
    t_line(3'd1, 1'b1, 1'b1, 1280, 112, 2);
    t_line(3'd2, 1'b0, 1'b0, 704, 688, 2);
    t_line(3'd3, 1'b1, 1'b0, 640, 56, 4);
    t_line(3'd4, 1'b0, 1'b1, 352, 344, 4);
    t_line(3'd5, 1'b1, 1'b0, 320, 376, 4);
    t_line(3'd6, 1'b0, 1'b0, 256, 440, 4);
    t_line(3'd7, 1'b1, 1'b0, 2560, 224, 1);
    t_ready;
    t_frame;
    t_underrun;
    t_latch;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule